// File: doc/BRIEF.md
# Configurable Product-Term Logic Block

This block is one logic cell of a programmable fabric. Eighteen logic inputs feed an array of product terms. Each term is the AND of a chosen set of input literals. Four outputs are built from these terms. For each output a static configuration picks one of two paths. The short path is the OR of four private terms. The long path ORs any subset of twenty shared terms and then XORs the result with one term that belongs to that output.

Each output can be taken straight from the logic or from a flip-flop. Three further terms serve as controls. One can clear the flip-flops asynchronously. One can clock the flip-flops in place of the block clock. One drives an output-enable signal that leaves the block next to the four outputs. All configuration is held static by the surrounding fabric. An active-low global reset clears all four flip-flops.

Top module: `plb_block`

## Requirements
- R1: Term t reads its mask from `pt_mask_i[t*36 +: 36]`. Bit 2i means "input i true" and bit 2i+1 means "input i complemented". The term is the AND of all selected literals. A term with no bit set is 0. A term that selects both literals of one input is 0.
- R2: When `bypass_i[k]`=1, the logic of output k is the OR of terms 4k to 4k+3. The XOR term of output k has no effect in this mode.
- R3: When `bypass_i[k]`=0, the logic of output k is the OR of those shared terms 0..19 whose bit j is set in `sum_sel_i[k*20 +: 20]`. That OR is then XORed with term 20+k.
- R4: When `reg_en_i[k]`=0, `out_o[k]` follows the logic of output k with no clock edge.
- R5: When `reg_en_i[k]`=1 and `clk_pt_en_i`=0, `out_o[k]` takes the logic value at each rising edge of `clk` and holds it between edges.
- R6: When `clk_pt_en_i`=1, the flip-flops capture on the rising edge of term 25 and ignore `clk`.
- R7: When `rst_pt_en_i`=1 and term 24 is 1, all four flip-flops are cleared at once, without waiting for a clock. They stay clear while the term is held.
- R8: `oe_o` equals term 26 when `oe_pt_en_i`=1, and is 1 otherwise.
- R9: While `rst_n`=0, all four flip-flops are cleared asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock for the flip-flops |
| rst_n | input | 1 | Global reset, active low |
| in_i | input | 18 | Logic inputs |
| pt_mask_i | input | 972 | Literal masks, 36 bits per term, 27 terms |
| sum_sel_i | input | 80 | Shared-term selection, 20 bits per output |
| bypass_i | input | 4 | 1 selects the 4-term short path |
| reg_en_i | input | 4 | 1 selects the flip-flop output |
| rst_pt_en_i | input | 1 | Use term 24 as asynchronous clear |
| clk_pt_en_i | input | 1 | Use term 25 as flip-flop clock |
| oe_pt_en_i | input | 1 | Use term 26 as output enable |
| out_o | output | 4 | Block outputs |
| oe_o | output | 1 | Output enable |

## Verification
One fixed configuration drives the combinational checks. It contains two short-path outputs and two long-path outputs. It also contains an empty term, a self-contradicting term, an 18-input-wide term and an XOR term that is attached to a short-path output. Input vectors toggle a single literal at a time, so each check shows one effect: a true literal against a complemented one, an XOR term that inverts the long path against one that is ignored on the short path, and a wide AND that is met only when all inputs are 1. Directed sequences then tell apart capture on `clk` from capture on the clock term, a clear that acts at once from one that waits for an edge, and the output enable taken from its term from the output enable held high.

// File: rtl/plb_pkg.sv
package plb_pkg;
  localparam int unsigned LIT_TRUE = 0;
  localparam int unsigned LIT_COMP = 1;
  localparam int unsigned CTRL_TERMS = 3;

  typedef struct packed {
    logic rst_en;
    logic clk_en;
    logic oe_en;
  } ctrl_sel_t;

  function automatic logic mask_conflict(input logic [71:0] m, input int unsigned n);
    logic c;
    c = 1'b0;
    for (int unsigned i = 0; i < n; i++) begin
      if (m[2*i+LIT_TRUE] && m[2*i+LIT_COMP]) c = 1'b1;
    end
    return c;
  endfunction
endpackage

// File: rtl/plb_pterm.sv
module plb_pterm #(
  parameter int unsigned NUM_IN = 18
) (
  input  logic [NUM_IN-1:0]   in_i,
  input  logic [2*NUM_IN-1:0] mask_i,
  output logic                term_o
);
  import plb_pkg::*;

  always_comb begin
    logic acc;
    acc = |mask_i;
    for (int unsigned i = 0; i < NUM_IN; i++) begin
      if (mask_i[2*i+LIT_TRUE] && !in_i[i]) acc = 1'b0;
      if (mask_i[2*i+LIT_COMP] && in_i[i])  acc = 1'b0;
    end
    term_o = acc;
  end
endmodule

// File: rtl/plb_ctrl.sv
module plb_ctrl (
  input  logic                clk,
  input  logic                rst_n,
  input  plb_pkg::ctrl_sel_t  sel_i,
  input  logic                pt_rst_i,
  input  logic                pt_clk_i,
  input  logic                pt_oe_i,
  output logic                reg_clk_o,
  output logic                arst_o,
  output logic                oe_o
);
  assign reg_clk_o = sel_i.clk_en ? pt_clk_i : clk;
  assign arst_o    = !rst_n || (sel_i.rst_en && pt_rst_i);
  assign oe_o      = sel_i.oe_en ? pt_oe_i : 1'b1;
endmodule

// File: rtl/plb_macrocell.sv
module plb_macrocell #(
  parameter int unsigned NUM_SUM = 20,
  parameter int unsigned BYP_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SUM-1:0] shared_pt_i,
  input  logic [BYP_W-1:0]   byp_pt_i,
  input  logic               xor_pt_i,
  input  logic [NUM_SUM-1:0] sum_sel_i,
  input  logic               bypass_i,
  input  logic               reg_en_i,
  input  logic               reg_clk_i,
  input  logic               arst_i,
  input  logic               clk_pt_sel_i,
  output logic               out_o
);
  logic sum_or;
  logic logic_d;
  logic q;

  assign sum_or  = |(shared_pt_i & sum_sel_i);
  assign logic_d = bypass_i ? (|byp_pt_i) : (sum_or ^ xor_pt_i);

  always_ff @(posedge reg_clk_i or posedge arst_i) begin
    if (arst_i) q <= 1'b0;
    else        q <= logic_d;
  end

  assign out_o = reg_en_i ? q : logic_d;

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_pt_sel_i && !arst_i) |=> (arst_i || q == $past(logic_d)));

  assert_pt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arst_i |-> (q == 1'b0));
endmodule

// File: rtl/plb_block.sv
module plb_block #(
  parameter int unsigned NUM_IN  = 18,
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned NUM_SUM = 20,
  parameter int unsigned BYP_W   = 4,
  localparam int unsigned MASK_W = 2 * NUM_IN,
  localparam int unsigned NUM_PT = NUM_SUM + NUM_OUT + plb_pkg::CTRL_TERMS,
  localparam int unsigned XOR_BASE = NUM_SUM,
  localparam int unsigned RST_PT = NUM_SUM + NUM_OUT,
  localparam int unsigned CLK_PT = RST_PT + 1,
  localparam int unsigned OE_PT  = RST_PT + 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_IN-1:0]           in_i,
  input  logic [NUM_PT*MASK_W-1:0]    pt_mask_i,
  input  logic [NUM_OUT*NUM_SUM-1:0]  sum_sel_i,
  input  logic [NUM_OUT-1:0]          bypass_i,
  input  logic [NUM_OUT-1:0]          reg_en_i,
  input  logic                        rst_pt_en_i,
  input  logic                        clk_pt_en_i,
  input  logic                        oe_pt_en_i,
  output logic [NUM_OUT-1:0]          out_o,
  output logic                        oe_o
);
  import plb_pkg::*;

  logic [NUM_PT-1:0] pt;
  logic              reg_clk;
  logic              arst;
  ctrl_sel_t         csel;

  genvar t;
  generate
    for (t = 0; t < NUM_PT; t++) begin : g_pt
      plb_pterm #(.NUM_IN(NUM_IN)) u_pt (
        .in_i   (in_i),
        .mask_i (pt_mask_i[t*MASK_W +: MASK_W]),
        .term_o (pt[t])
      );

      assert_empty_term_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_mask_i[t*MASK_W +: MASK_W] == '0) |-> !pt[t]);

      assert_conflict_term_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mask_conflict(72'(pt_mask_i[t*MASK_W +: MASK_W]), NUM_IN) |-> !pt[t]);
    end
  endgenerate

  assign csel = '{rst_en: rst_pt_en_i, clk_en: clk_pt_en_i, oe_en: oe_pt_en_i};

  plb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (csel),
    .pt_rst_i  (pt[RST_PT]),
    .pt_clk_i  (pt[CLK_PT]),
    .pt_oe_i   (pt[OE_PT]),
    .reg_clk_o (reg_clk),
    .arst_o    (arst),
    .oe_o      (oe_o)
  );

  genvar k;
  generate
    for (k = 0; k < NUM_OUT; k++) begin : g_mc
      plb_macrocell #(.NUM_SUM(NUM_SUM), .BYP_W(BYP_W)) u_mc (
        .clk          (clk),
        .rst_n        (rst_n),
        .shared_pt_i  (pt[NUM_SUM-1:0]),
        .byp_pt_i     (pt[k*BYP_W +: BYP_W]),
        .xor_pt_i     (pt[XOR_BASE+k]),
        .sum_sel_i    (sum_sel_i[k*NUM_SUM +: NUM_SUM]),
        .bypass_i     (bypass_i[k]),
        .reg_en_i     (reg_en_i[k]),
        .reg_clk_i    (reg_clk),
        .arst_i       (arst),
        .clk_pt_sel_i (clk_pt_en_i),
        .out_o        (out_o[k])
      );
    end
  endgenerate

  initial begin
    assert_bypass_fits_R2: assert (NUM_OUT * BYP_W <= NUM_SUM);
  end
endmodule

// File: tb/plb_block_tb_top.sv
`timescale 1ns/1ps
module plb_block_tb_top;
  localparam int NI = 18;
  localparam int W  = 36;
  localparam int NP = 27;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n;
  logic [NI-1:0] in_i;
  logic [NP*W-1:0] pt_mask;
  logic [79:0] sum_sel;
  logic [3:0] bypass, reg_en, out_o;
  logic rst_pt_en, clk_pt_en, oe_pt_en, oe_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  plb_block dut_i (
    .clk(clk), .rst_n(rst_n), .in_i(in_i), .pt_mask_i(pt_mask),
    .sum_sel_i(sum_sel), .bypass_i(bypass), .reg_en_i(reg_en),
    .rst_pt_en_i(rst_pt_en), .clk_pt_en_i(clk_pt_en), .oe_pt_en_i(oe_pt_en),
    .out_o(out_o), .oe_o(oe_o)
  );

  localparam logic [17:0] VIN [NV] = '{18'h00000, 18'h00007, 18'h00004, 18'h00074,
    18'h000F4, 18'h00104, 18'h00107, 18'h00404, 18'h00604, 18'h3FFFF,
    18'h20004, 18'h00008, 18'h3FFFB};
  localparam logic [3:0] VEXP [NV] = '{4'b0001, 4'b0101, 4'b0000, 4'b0110,
    4'b0110, 4'b0100, 4'b0001, 4'b1000, 4'b0000, 4'b1011,
    4'b0100, 4'b0001, 4'b0011};

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic lit(input int t, input int i, input int comp);
    pt_mask[t*W + 2*i + comp] = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_i = '0; pt_mask = '0; sum_sel = '0;
    bypass = 4'b0011; reg_en = 4'hF; rst_pt_en = 0; clk_pt_en = 0; oe_pt_en = 0;
    lit(0, 0, 0); lit(0, 1, 0);
    lit(1, 2, 1);
    lit(3, 3, 0); lit(3, 3, 1);
    lit(4, 4, 0); lit(4, 5, 0); lit(4, 6, 0);
    lit(21, 7, 0);
    lit(22, 8, 0);
    lit(16, 17, 0);
    lit(17, 9, 1); lit(17, 10, 0);
    for (int i = 0; i < NI; i++) lit(18, i, 0);
    lit(24, 11, 0);
    lit(25, 12, 0);
    lit(26, 13, 1);
    sum_sel[40+0] = 1; sum_sel[40+4] = 1; sum_sel[40+16] = 1;
    sum_sel[60+17] = 1; sum_sel[60+18] = 1;

    in_i = 18'h00007;
    repeat (3) @(negedge clk);
    #1 chk("R9 reset clears registers", out_o, 4'b0000);

    reg_en = 4'h0;
    @(negedge clk); rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk); in_i = VIN[v];
      #1 chk($sformatf("R1 R2 R3 R4 vector %0d", v), out_o, VEXP[v]);
    end

    @(negedge clk); rst_n = 1'b0; reg_en = 4'hF; in_i = '0;
    #1 chk("R9 registers clear", out_o, 4'b0000);
    @(negedge clk); rst_n = 1'b1; in_i = 18'h00007;
    #1 chk("R5 holds before edge", out_o, 4'b0000);
    @(negedge clk);
    chk("R5 captured on clk", out_o, 4'b0101);
    in_i = 18'h00074;
    @(negedge clk);
    chk("R5 second capture", out_o, 4'b0110);

    rst_pt_en = 1'b1;
    in_i = 18'h00874;
    #1 chk("R7 term clears at once", out_o, 4'b0000);
    @(negedge clk);
    chk("R7 clear held over edge", out_o, 4'b0000);
    in_i = 18'h00074;
    #1 chk("R7 stays clear until edge", out_o, 4'b0000);
    @(negedge clk);
    chk("R7 capture after release", out_o, 4'b0110);

    rst_n = 1'b0;
    #1 chk("R9 async global reset", out_o, 4'b0000);

    @(negedge clk); rst_pt_en = 1'b0; clk_pt_en = 1'b1; in_i = 18'h00007;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 clk ignored", out_o, 4'b0000);
    in_i = 18'h01007;
    #1 chk("R6 capture on term edge", out_o, 4'b0101);
    @(negedge clk); in_i = 18'h01074;
    repeat (2) @(negedge clk);
    chk("R6 hold while term high", out_o, 4'b0101);
    in_i = 18'h00074;
    #1 chk("R6 no capture on falling term", out_o, 4'b0101);
    in_i = 18'h01074;
    #1 chk("R6 second term edge", out_o, 4'b0110);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); clk_pt_en = 1'b0; rst_n = 1'b1;
    in_i = 18'h02000;
    #1 chk("R8 enable fixed high", {3'b000, oe_o}, 4'b0001);
    oe_pt_en = 1'b1;
    #1 chk("R8 term low drives oe low", {3'b000, oe_o}, 4'b0000);
    in_i = 18'h00000;
    #1 chk("R8 term high drives oe high", {3'b000, oe_o}, 4'b0001);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule